// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. A one-cycle enable, `tick`, runs at sixteen times the bit rate. The receiver looks at the line only on those ticks. A character begins with a low level. That low level counts as a start bit only when it holds long enough to rule out a glitch. After a start bit is accepted, the receiver samples each later bit in the middle of its slot: the data bits, then a parity bit if one is enabled, then a single stop bit.

Each finished character is written to an output holding register, and a ready flag is raised. A one-cycle read strobe lowers the flag. Two sticky error flags record a low stop bit and a parity mismatch. A reset command disables the receiver at once and drops any partial character. A separate enable command arms the receiver again.

Top module: `serial_rx_core`

## Requirements
- R1: The line passes through a two-stage synchronizer and is examined only in cycles where `tick` is high. Cycles without a tick, however many there are, do not move reception forward. One bit lasts 16 ticks.
- R2: A start bit is accepted only when the line reads low on 8 consecutive ticks. A low of 1 to 7 ticks is dropped, and the receiver returns to waiting for a falling edge.
- R3: Data bit 0 is sampled on the 24th tick after the tick on which the low was first seen. Each later bit is sampled 16 ticks after the one before it. The line values on all other ticks of a bit have no effect.
- R4: The frame has one start bit, 8 data bits sent least significant bit first, and one stop bit. When `par_en` is 1, a parity bit is inserted between the data bits and the stop bit.
- R5: When the stop bit is sampled, `rx_data` takes the character and `rx_ready` rises on that same clock edge. `rx_data` changes at no other time.
- R6: A high `rd_strobe` clears `rx_ready` on the next edge. If a new character is stored on that same edge, `rx_ready` stays 1.
- R7: `cmd_reset` stops and disables the receiver at once, and a partial character is lost. It does not change `rx_ready` or `rx_data`. When `cmd_reset` and `cmd_enable` arrive in the same cycle, the reset wins and the receiver stays disabled.
- R8: `cmd_enable` arms a disabled receiver. A start is then recognised only after the line has been seen high on a tick and then seen low. A line that is already low when the receiver is enabled starts nothing.
- R9: A stop bit sampled low sets `frame_err`. When `par_odd` is 0 (even parity), `par_err` is set if the XOR of the 8 data bits and the parity bit is 1. When `par_odd` is 1 (odd parity), `par_err` is set if that XOR is 0. Both flags are sticky until `cmd_reset`, which clears them.
- R10: After `rst_n` is released, `rx_ready`, `frame_err` and `par_err` are 0, `rx_data` is 0, and the receiver is disabled until `cmd_enable` is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling enable, 16 per bit |
| rxd | input | 1 | Asynchronous serial line, idles high |
| cmd_reset | input | 1 | Receiver reset command, one-cycle pulse |
| cmd_enable | input | 1 | Receiver enable command, one-cycle pulse |
| par_en | input | 1 | 1 = a parity bit follows the data bits |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Holding-register read, clears the ready flag |
| rx_data | output | 8 | Last character received |
| rx_ready | output | 1 | A character is waiting to be read |
| frame_err | output | 1 | Sticky flag: a stop bit was sampled low |
| par_err | output | 1 | Sticky flag: a parity mismatch was seen |

## Verification
A read strobe and the storing of a new character can fall on the same clock edge. The bench provokes this by leaving one character unread and then asserting `rd_strobe` together with the tick on which the next stop bit is sampled. It expects `rx_ready` to stay high and `rx_data` to hold the new value. A second collision pairs `cmd_reset` with `cmd_enable` in one cycle. The bench then sends a complete frame and expects no store, with the old data and flag left unchanged.

// File: rtl/rx_pkg.sv
package rx_pkg;
   typedef enum logic [2:0] {
      RX_OFF,
      RX_ARM,
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], din};
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import rx_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int OVS            = 16,
   parameter int START_LOW      = 8,
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              cmd_reset,
   input  logic              cmd_enable,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              store_ev,
   output logic [DATA_W-1:0] cap_data,
   output logic              cap_ferr,
   output logic              cap_perr
);
   localparam int PH_W = $clog2(OVS);
   localparam int BN_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [PH_W-1:0] MID_PH  = PH_W'(OVS / 2);
   localparam logic [PH_W-1:0] LOW_MIN = PH_W'(START_LOW);
   localparam logic [BN_W-1:0] LAST_BN = BN_W'(DATA_W - 1);

   rx_state_e         st;
   logic [PH_W-1:0]   ph;
   logic [PH_W-1:0]   ph_n;
   logic [BN_W-1:0]   bn;
   logic [DATA_W-1:0] sh;
   logic              pbit;
   logic              par_on;
   logic              perr_calc;
   logic              at_mid;

   assign ph_n   = ph + 1'b1;
   assign at_mid = tick && (ph_n == MID_PH);

   generate
      if (PARITY_SUPPORT) begin : g_par
         assign par_on    = par_en;
         assign perr_calc = (^sh) ^ pbit ^ par_odd;
      end else begin : g_nopar
         assign par_on    = 1'b0;
         assign perr_calc = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_OFF;
         ph   <= '0;
         bn   <= '0;
         sh   <= '0;
         pbit <= 1'b0;
      end else if (cmd_reset) begin
         st <= RX_OFF;
      end else begin
         unique case (st)
            RX_OFF:  if (cmd_enable) st <= RX_ARM;
            RX_ARM:  if (tick && line) st <= RX_IDLE;
            RX_IDLE: if (tick && !line) begin
               st <= RX_START;
               ph <= '0;
            end
            RX_START: if (tick) begin
               ph <= ph_n;
               if (line && (ph_n < LOW_MIN)) st <= RX_IDLE;
               else if (ph_n == MID_PH) begin
                  st <= RX_DATA;
                  bn <= '0;
               end
            end
            RX_DATA: if (tick) begin
               ph <= ph_n;
               if (at_mid) begin
                  sh <= {line, sh[DATA_W-1:1]};
                  if (bn == LAST_BN) st <= par_on ? RX_PAR : RX_STOP;
                  else               bn <= bn + 1'b1;
               end
            end
            RX_PAR: if (tick) begin
               ph <= ph_n;
               if (at_mid) begin
                  pbit <= line;
                  st   <= RX_STOP;
               end
            end
            RX_STOP: if (tick) begin
               ph <= ph_n;
               if (at_mid) st <= RX_ARM;
            end
            default: st <= RX_OFF;
         endcase
      end
   end

   assign store_ev = (st == RX_STOP) && at_mid && !cmd_reset;
   assign cap_data = sh;
   assign cap_ferr = !line;
   assign cap_perr = par_on && perr_calc;
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_ev,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              cap_ferr,
   input  logic              cap_perr,
   input  logic              rd_strobe,
   input  logic              cmd_reset,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              frame_err,
   output logic              par_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_ready <= 1'b0;
      end else begin
         if (store_ev) rx_data <= cap_data;
         if (store_ev)       rx_ready <= 1'b1;
         else if (rd_strobe) rx_ready <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_err <= 1'b0;
         par_err   <= 1'b0;
      end else if (cmd_reset) begin
         frame_err <= 1'b0;
         par_err   <= 1'b0;
      end else if (store_ev) begin
         frame_err <= frame_err | cap_ferr;
         par_err   <= par_err | cap_perr;
      end
   end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
   parameter int DATA_W         = 8,
   parameter int OVS            = 16,
   parameter int START_LOW      = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              cmd_reset,
   input  logic              cmd_enable,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              frame_err,
   output logic              par_err
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (START_LOW < 1 || START_LOW > OVS / 2) begin : g_bad_low
         $error("START_LOW must lie in 1..OVS/2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              line_s;
   logic              store_ev;
   logic [DATA_W-1:0] cap_data;
   logic              cap_ferr;
   logic              cap_perr;

   rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (line_s)
   );

   rx_frame_fsm #(
      .DATA_W        (DATA_W),
      .OVS           (OVS),
      .START_LOW     (START_LOW),
      .PARITY_SUPPORT(PARITY_SUPPORT)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .line      (line_s),
      .cmd_reset (cmd_reset),
      .cmd_enable(cmd_enable),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .store_ev  (store_ev),
      .cap_data  (cap_data),
      .cap_ferr  (cap_ferr),
      .cap_perr  (cap_perr)
   );

   rx_hold_reg #(.DATA_W(DATA_W)) i_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .store_ev (store_ev),
      .cap_data (cap_data),
      .cap_ferr (cap_ferr),
      .cap_perr (cap_perr),
      .rd_strobe(rd_strobe),
      .cmd_reset(cmd_reset),
      .rx_data  (rx_data),
      .rx_ready (rx_ready),
      .frame_err(frame_err),
      .par_err  (par_err)
   );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              cmd_reset,
   input logic              rd_strobe,
   input logic              store_ev,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_ready,
   input logic              frame_err,
   input logic              par_err
);
   AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |-> $past(tick)); // R5
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !store_ev |=> $stable(rx_data)); // R5
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !store_ev) |=> !rx_ready); // R6
   AST_STORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      store_ev |=> rx_ready); // R6
   AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> !store_ev); // R7
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (!frame_err && !par_err)); // R9
   AST_FERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> $past(store_ev)); // R9
endmodule

bind serial_rx_core serial_rx_core_chk #(.DATA_W(DATA_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .cmd_reset(cmd_reset),
   .rd_strobe(rd_strobe),
   .store_ev (store_ev),
   .rx_data  (rx_data),
   .rx_ready (rx_ready),
   .frame_err(frame_err),
   .par_err  (par_err)
);

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, tick, rxd, cmd_reset, cmd_enable, par_en, par_odd, rd_strobe;
   logic [7:0] rx_data;
   logic       rx_ready, frame_err, par_err;
   int total = 0;
   int bad   = 0;
   int gap   = 0;
   bit done  = 1'b0;

   serial_rx_core i_serial_rx_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .cmd_reset(cmd_reset), .cmd_enable(cmd_enable),
      .par_en(par_en), .par_odd(par_odd), .rd_strobe(rd_strobe),
      .rx_data(rx_data), .rx_ready(rx_ready),
      .frame_err(frame_err), .par_err(par_err)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // rxd is set at a negedge; two edges fill the synchronizer before the tick edge
   task automatic one_tick(bit rd);
      repeat (gap) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      tick = 1'b1; rd_strobe = rd;
      @(negedge clk);
      tick = 1'b0; rd_strobe = 1'b0;
   endtask

   task automatic ticks(bit v, int n);
      rxd = v;
      repeat (n) one_tick(1'b0);
   endtask

   task automatic pulse(bit r, bit e, bit rd);
      @(negedge clk);
      cmd_reset = r; cmd_enable = e; rd_strobe = rd;
      @(negedge clk);
      cmd_reset = 1'b0; cmd_enable = 1'b0; rd_strobe = 1'b0;
   endtask

   // pm: 0 none, 1 even, 2 odd
   task automatic send_frame(logic [7:0] d, int pm, bit badp, bit bads, bit mid, bit rdstop);
      logic sl [12];
      int   n;
      logic p;
      p = (pm == 2) ? ~(^d) : (^d);
      if (badp) p = ~p;
      sl[0] = 1'b0;
      for (int i = 0; i < 8; i++) sl[1+i] = d[i];
      n = 9;
      if (pm != 0) begin sl[n] = p; n++; end
      sl[n] = ~bads; n++;
      ticks(1'b1, 2);
      for (int k = 0; k < n; k++) begin
         for (int j = 0; j < 16; j++) begin
            rxd = (mid && k != 0 && j != 8) ? ~sl[k] : sl[k];
            one_tick(rdstop && (k == n - 1) && (j == 8));
         end
      end
      ticks(1'b1, 2);
   endtask

   task automatic check_frame(string req, logic [7:0] d, bit ep, bit ef);
      check({req, " ready"}, rx_ready, 1);
      check({req, " data"}, rx_data, d);
      check({req, " R9 frame_err"}, frame_err, ef);
      check({req, " R9 par_err"}, par_err, ep);
      pulse(1'b0, 1'b0, 1'b1);
      check("R6 read clears ready", rx_ready, 0);
      if (ep || ef) begin
         pulse(1'b1, 1'b0, 1'b0);
         check("R9 reset clears frame_err", frame_err, 0);
         check("R9 reset clears par_err", par_err, 0);
         pulse(1'b0, 1'b1, 1'b0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      bit bp, bs;
      rst_n = 1'b0; tick = 1'b0; rxd = 1'b1; cmd_reset = 1'b0; cmd_enable = 1'b0;
      par_en = 1'b0; par_odd = 1'b0; rd_strobe = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset ready", rx_ready, 0);
      check("R10 reset data", rx_data, 0);
      check("R10 reset frame_err", frame_err, 0);
      check("R10 reset par_err", par_err, 0);

      // R10: disabled until enabled
      send_frame(8'h5A, 0, 0, 0, 0, 0);
      check("R10 disabled receives nothing", rx_ready, 0);
      pulse(1'b0, 1'b1, 1'b0);

      // R4 R5 R9: sweep over the three parity modes
      for (int m = 0; m < 3; m++) begin
         par_en = (m != 0); par_odd = (m == 2);
         for (int i = 0; i < 40; i++) begin
            d  = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 53 + m * 17 + 7) & 255);
            bp = (m != 0) && (i % 5 == 2);
            bs = (i % 7 == 3);
            send_frame(d, m, bp, bs, 0, 0);
            check_frame("R4 R5 sweep", d, bp, bs);
         end
      end

      // R1 R3: only the mid tick of each bit carries the value; idle cycles between ticks
      par_en = 1'b1; par_odd = 1'b0; gap = 5;
      for (int i = 0; i < 4; i++) begin
         d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'hA5 : 8'h3C;
         send_frame(d, 1, 0, 0, 1, 0);
         check_frame("R1 R3 midpoint", d, 0, 0);
      end
      gap = 0; par_en = 1'b0;

      // R2: short lows are dropped
      for (int k = 1; k <= 7; k++) begin
         ticks(1'b1, 2); ticks(1'b0, k); ticks(1'b1, 200);
         check("R2 short low ignored", rx_ready, 0);
         check("R2 short low no frame_err", frame_err, 0);
      end
      // R2: exactly 8 low ticks is a start; all later bits read high
      ticks(1'b1, 2); ticks(1'b0, 8); ticks(1'b1, 200);
      check("R2 eight-tick start ready", rx_ready, 1);
      check("R2 eight-tick start data", rx_data, 8'hFF);
      check("R2 eight-tick start frame_err", frame_err, 0);
      pulse(1'b0, 1'b0, 1'b1);

      // R7: reset mid-character drops it
      ticks(1'b1, 2); ticks(1'b0, 16); ticks(1'b1, 16); ticks(1'b0, 32);
      pulse(1'b1, 1'b0, 1'b0);
      ticks(1'b1, 120);
      check("R7 aborted char not stored", rx_ready, 0);
      check("R7 data untouched by reset", rx_data, 8'hFF);
      pulse(1'b0, 1'b1, 1'b0);
      send_frame(8'h81, 0, 0, 0, 0, 0);
      check_frame("R8 re-armed", 8'h81, 0, 0);

      // R8: enabled while the line is low
      pulse(1'b1, 1'b0, 1'b0);
      rxd = 1'b0;
      pulse(1'b0, 1'b1, 1'b0);
      ticks(1'b0, 200);
      check("R8 low at enable no char", rx_ready, 0);
      check("R8 low at enable no frame_err", frame_err, 0);
      ticks(1'b1, 3);
      send_frame(8'h42, 0, 0, 0, 0, 0);
      check_frame("R8 after high", 8'h42, 0, 0);

      // R6: read on the store edge
      send_frame(8'h3C, 0, 0, 0, 0, 0);
      check("R6 unread ready", rx_ready, 1);
      send_frame(8'h17, 0, 0, 0, 0, 1);
      check("R6 store beats read ready", rx_ready, 1);
      check("R6 store beats read data", rx_data, 8'h17);
      pulse(1'b0, 1'b0, 1'b1);
      check("R6 later read clears", rx_ready, 0);

      // R7: reset and enable together
      send_frame(8'h66, 0, 0, 0, 0, 0);
      pulse(1'b1, 1'b1, 1'b0);
      check("R7 reset keeps ready", rx_ready, 1);
      check("R7 reset keeps data", rx_data, 8'h66);
      send_frame(8'h99, 0, 0, 0, 0, 0);
      check("R7 reset wins over enable", rx_data, 8'h66);
      pulse(1'b0, 1'b1, 1'b1);
      send_frame(8'h99, 0, 0, 0, 0, 0);
      check_frame("R7 after enable", 8'h99, 0, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule